// File: doc/BRIEF.md
# Fixed-Point Affine Coordinate Mapper

This block applies a 2x2 fixed-point matrix and an offset vector to a signed integer pixel coordinate pair. For every accepted coordinate it produces `X = gxx*x + gxy*y + ox` and `Y = gyx*x + gyy*y + oy`. The four gains and the two offsets are static configuration inputs that the surrounding logic changes only while no coordinate is in flight. The coordinate pair enters packed into one word with a valid strobe, and the mapped pair leaves packed into one registered word with its own valid flag.

Every intermediate width follows the fixed-point sizing rules. A product of formats with `i1` and `i2` integer bits (sign included) gets `i1+i2` integer bits and the summed fraction count. A sum gets one integer bit more than its wider operand and the larger fraction count. Products and sums therefore never overflow. The single lossy step is the final resize to the output format: the fraction is floored and the integer part saturates. The work is split into two register stages, so a result appears two cycles after its input, and a new coordinate may enter on every cycle.

Top module: `affine_coord_mapper`

## Requirements
- R1: The x coordinate is bits 10:0 of `in_coord` and the y coordinate is bits 21:11. Both are 11-bit two's-complement integers.
- R2: The x lane equals `gain_xx*x + gain_xy*y + ofs_x`. Gains have 3 integer bits (sign included) and 16 fraction bits. Offsets have 11 integer bits and 16 fraction bits. Results inside the output range are exact apart from the dropped fraction bits.
- R3: The y lane uses only `gain_yx`, `gain_yy` and `ofs_y`: `gain_yx*x + gain_yy*y + ofs_y`.
- R4: Each lane result is a signed value with 13 integer bits and 8 fraction bits. Fraction bits below 2^-8 are discarded toward negative infinity (floor), including for negative values.
- R5: A lane value above the largest output code saturates to 0x0FFFFF (just under +4096).
- R6: A lane value below the smallest output code saturates to 0x100000 (-4096).
- R7: `out_coord` bits 20:0 carry the x lane and bits 41:21 carry the y lane.
- R8: `out_valid` is high exactly in the cycle two clock edges after `in_valid` was sampled high. Back-to-back inputs produce back-to-back results.
- R9: While no result is delivered, `out_coord` keeps the last delivered value.
- R10: A synchronous active-high `rst` clears `out_valid`, the internal stage-1 valid and `out_coord` to zero, and discards results in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| gain_xx | input | 19 | Gain of x into X, signed 3.16 |
| gain_xy | input | 19 | Gain of y into X, signed 3.16 |
| gain_yx | input | 19 | Gain of x into Y, signed 3.16 |
| gain_yy | input | 19 | Gain of y into Y, signed 3.16 |
| ofs_x | input | 27 | Offset of X, signed 11.16 |
| ofs_y | input | 27 | Offset of Y, signed 11.16 |
| in_valid | input | 1 | Coordinate strobe |
| in_coord | input | 22 | Packed coordinate, y in 21:11 and x in 10:0 |
| out_valid | output | 1 | Result strobe |
| out_coord | output | 42 | Packed result, Y in 41:21 and X in 20:0, each signed 13.8 |

## Verification
The bound checker watches the control path on every cycle:
- the stage-1 valid follows `in_valid` by one edge;
- `out_valid` follows it by two edges;
- the output word stays unchanged when no result arrives;
- a reset leaves everything at zero.

Only the bench's scenarios can show the arithmetic: exact sums, floor on negative fractions, saturation at both rails, and correct lane and field placement. The bench sweeps a grid of edge and interior coordinates under fixed and random gain sets, and compares each result with an arithmetic model.

// File: rtl/affine_pkg.sv
`timescale 1ns/1ps
package affine_pkg;

  // Larger of two integers.
  function automatic int fx_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Integer bits (sign included) of a product of two signed formats.
  function automatic int fx_mul_ib(input int ia, input int ib);
    return ia + ib;
  endfunction

  // Integer bits of a sum of two signed formats.
  function automatic int fx_add_ib(input int ia, input int ib);
    return fx_max(ia, ib) + 1;
  endfunction

  // Fraction bits of a sum (a product adds the two fraction counts).
  function automatic int fx_add_fb(input int fa, input int fb);
    return fx_max(fa, fb);
  endfunction

endpackage

// File: rtl/affine_mul_pair.sv
`timescale 1ns/1ps
// Stage 1 of one lane: the two coefficient-by-coordinate products,
// registered at full width.
module affine_mul_pair #(
  parameter int GAIN_W = 19,
  parameter int CRD_W  = 11,
  localparam int PROD_W = GAIN_W + CRD_W
) (
  input  logic                     clk,
  input  logic signed [GAIN_W-1:0] g_x,
  input  logic signed [GAIN_W-1:0] g_y,
  input  logic signed [CRD_W-1:0]  crd_x,
  input  logic signed [CRD_W-1:0]  crd_y,
  output logic signed [PROD_W-1:0] prod_x,
  output logic signed [PROD_W-1:0] prod_y
);

  always_ff @(posedge clk) begin
    prod_x <= PROD_W'(g_x) * PROD_W'(crd_x);
    prod_y <= PROD_W'(g_y) * PROD_W'(crd_y);
  end

endmodule

// File: rtl/affine_sum_sat.sv
`timescale 1ns/1ps
// Stage 2 of one lane: full-precision three-term sum, then floor of the
// fraction and saturation of the integer part to the result format.
module affine_sum_sat
  import affine_pkg::*;
#(
  parameter int P_IB = 14,
  parameter int P_FB = 16,
  parameter int O_IB = 11,
  parameter int O_FB = 16,
  parameter int R_IB = 13,
  parameter int R_FB = 8,
  localparam int P_W    = P_IB + P_FB,
  localparam int O_W    = O_IB + O_FB,
  localparam int R_W    = R_IB + R_FB,
  localparam int PP_IB  = fx_add_ib(P_IB, P_IB),
  localparam int ACC_IB = fx_add_ib(PP_IB, O_IB),
  localparam int ACC_FB = fx_add_fb(P_FB, O_FB),
  localparam int ACC_W  = ACC_IB + ACC_FB,
  localparam int DROP   = ACC_FB - R_FB
) (
  input  logic signed [P_W-1:0] prod_x,
  input  logic signed [P_W-1:0] prod_y,
  input  logic signed [O_W-1:0] ofs,
  output logic        [R_W-1:0] res
);

  logic signed [ACC_W-1:0] al_x, al_y, al_o, acc, flr;
  logic        [ACC_W-R_W:0] hi;
  logic                      ovf_pos, ovf_neg;

  always_comb begin
    al_x = ACC_W'(prod_x) <<< (ACC_FB - P_FB);
    al_y = ACC_W'(prod_y) <<< (ACC_FB - P_FB);
    al_o = ACC_W'(ofs)    <<< (ACC_FB - O_FB);
    acc  = al_x + al_y + al_o;
    flr  = acc >>> DROP;
    hi   = flr[ACC_W-1:R_W-1];
    ovf_pos = !flr[ACC_W-1] && (|hi);
    ovf_neg =  flr[ACC_W-1] && !(&hi);
    if (ovf_pos)
      res = {1'b0, {(R_W-1){1'b1}}};
    else if (ovf_neg)
      res = {1'b1, {(R_W-1){1'b0}}};
    else
      res = flr[R_W-1:0];
  end

endmodule

// File: rtl/affine_coord_mapper.sv
`timescale 1ns/1ps
module affine_coord_mapper
  import affine_pkg::*;
#(
  parameter int GAIN_IB = 3,
  parameter int GAIN_FB = 16,
  parameter int CRD_W   = 11,
  parameter int OFS_IB  = 11,
  parameter int OFS_FB  = 16,
  parameter int OUT_IB  = 13,
  parameter int OUT_FB  = 8,
  localparam int GAIN_W = GAIN_IB + GAIN_FB,
  localparam int OFS_W  = OFS_IB + OFS_FB,
  localparam int RES_W  = OUT_IB + OUT_FB,
  localparam int PROD_IB = fx_mul_ib(GAIN_IB, CRD_W),
  localparam int PROD_W  = GAIN_W + CRD_W,
  localparam int LANES   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [GAIN_W-1:0]      gain_xx,
  input  logic [GAIN_W-1:0]      gain_xy,
  input  logic [GAIN_W-1:0]      gain_yx,
  input  logic [GAIN_W-1:0]      gain_yy,
  input  logic [OFS_W-1:0]       ofs_x,
  input  logic [OFS_W-1:0]       ofs_y,
  input  logic                   in_valid,
  input  logic [2*CRD_W-1:0]     in_coord,
  output logic                   out_valid,
  output logic [LANES*RES_W-1:0] out_coord
);

  logic signed [CRD_W-1:0]  crd_x, crd_y;
  logic signed [GAIN_W-1:0] gain_m [LANES][2];
  logic signed [OFS_W-1:0]  ofs_v  [LANES];
  logic signed [PROD_W-1:0] prod_x [LANES];
  logic signed [PROD_W-1:0] prod_y [LANES];
  logic [RES_W-1:0]         lane_res [LANES];
  logic [LANES*RES_W-1:0]   packed_res;
  logic                     s1_valid;

  assign crd_x = in_coord[CRD_W-1:0];
  assign crd_y = in_coord[2*CRD_W-1:CRD_W];

  assign gain_m[0][0] = gain_xx;
  assign gain_m[0][1] = gain_xy;
  assign gain_m[1][0] = gain_yx;
  assign gain_m[1][1] = gain_yy;
  assign ofs_v[0]     = ofs_x;
  assign ofs_v[1]     = ofs_y;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    affine_mul_pair #(
      .GAIN_W (GAIN_W),
      .CRD_W  (CRD_W)
    ) u_mul (
      .clk    (clk),
      .g_x    (gain_m[i][0]),
      .g_y    (gain_m[i][1]),
      .crd_x  (crd_x),
      .crd_y  (crd_y),
      .prod_x (prod_x[i]),
      .prod_y (prod_y[i])
    );

    affine_sum_sat #(
      .P_IB (PROD_IB),
      .P_FB (GAIN_FB),
      .O_IB (OFS_IB),
      .O_FB (OFS_FB),
      .R_IB (OUT_IB),
      .R_FB (OUT_FB)
    ) u_sum (
      .prod_x (prod_x[i]),
      .prod_y (prod_y[i]),
      .ofs    (ofs_v[i]),
      .res    (lane_res[i])
    );

    assign packed_res[i*RES_W +: RES_W] = lane_res[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
      out_coord <= '0;
    end else begin
      s1_valid  <= in_valid;
      out_valid <= s1_valid;
      if (s1_valid)
        out_coord <= packed_res;
    end
  end

endmodule

// File: rtl/affine_coord_mapper_chk.sv
`timescale 1ns/1ps
module affine_coord_mapper_chk #(
  parameter int OUT_W = 42
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             s1_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_coord
);

  // Non-reset edges seen since the last reset, capped at 3.
  logic [1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)
      run_cnt <= 2'd0;
    else if (run_cnt != 2'd3)
      run_cnt <= run_cnt + 2'd1;
  end

  // R8
  stage1_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 2'd1) |-> (s1_valid == $past(in_valid)));

  // R8
  latency_two_chk: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ((run_cnt >= 2'd1) && !$past(s1_valid)) |-> $stable(out_coord));

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !s1_valid && (out_coord == '0)));

endmodule

bind affine_coord_mapper affine_coord_mapper_chk #(
  .OUT_W (LANES*RES_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .s1_valid  (s1_valid),
  .out_valid (out_valid),
  .out_coord (out_coord)
);

// File: tb/affine_coord_mapper_test.sv
`timescale 1ns/1ps
module affine_coord_mapper_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [18:0] gain_xx, gain_xy, gain_yx, gain_yy;
  logic [26:0] ofs_x, ofs_y;
  logic        in_valid = 1'b0;
  logic [21:0] in_coord = '0;
  logic        out_valid;
  logic [41:0] out_coord;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 0;

  longint cg[4];
  longint co[2];

  bit          ev[2];
  logic [41:0] ew[2];
  string       etx[2];
  string       ety[2];
  logic [41:0] last_out;

  localparam longint RMAX = 1048575;
  localparam longint RMIN = -1048576;

  always #10 clk = ~clk;

  affine_coord_mapper uut (
    .clk(clk), .rst(rst),
    .gain_xx(gain_xx), .gain_xy(gain_xy), .gain_yx(gain_yx), .gain_yy(gain_yy),
    .ofs_x(ofs_x), .ofs_y(ofs_y),
    .in_valid(in_valid), .in_coord(in_coord),
    .out_valid(out_valid), .out_coord(out_coord)
  );

  function automatic longint lane_q(input longint s);
    longint f = s >>> 8;
    if (f > RMAX) f = RMAX;
    if (f < RMIN) f = RMIN;
    return f;
  endfunction

  function automatic string lane_tag(input longint s, input string base);
    longint f = s >>> 8;
    if (f > RMAX) return "R5";
    if (f < RMIN) return "R6";
    if ((s & 255) != 0) return "R4";
    return base;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive_cfg();
    gain_xx = 19'(cg[0]); gain_xy = 19'(cg[1]);
    gain_yx = 19'(cg[2]); gain_yy = 19'(cg[3]);
    ofs_x = 27'(co[0]);   ofs_y = 27'(co[1]);
  endtask

  // Compare outputs seen now with the entry pushed two steps ago.
  task automatic check_out();
    check("R8", longint'(out_valid), longint'(ev[1]));
    if (ev[1]) begin
      check(etx[1], longint'(out_coord[20:0]),  longint'(ew[1][20:0]));
      check(ety[1], longint'(out_coord[41:21]), longint'(ew[1][41:21]));
      last_out = ew[1];
    end else begin
      check("R9", longint'(out_coord), longint'(last_out));
    end
  endtask

  task automatic step(input bit v, input int x, input int y,
                      input string tx = "", input string ty = "");
    longint sx, sy;
    @(negedge clk);
    check_out();
    ev[1] = ev[0]; ew[1] = ew[0]; etx[1] = etx[0]; ety[1] = ety[0];
    sx = cg[0] * x + cg[1] * y + co[0];
    sy = cg[2] * x + cg[3] * y + co[1];
    ev[0]  = v;
    ew[0]  = {21'(lane_q(sy)), 21'(lane_q(sx))};
    etx[0] = (tx != "") ? tx : lane_tag(sx, "R2");
    ety[0] = (ty != "") ? ty : lane_tag(sy, "R3");
    in_valid = v;
    in_coord = {11'(y), 11'(x)};
  endtask

  task automatic clear_model();
    ev[0] = 0; ev[1] = 0; last_out = '0;
  endtask

  task automatic new_cfg(input longint a, input longint b, input longint c,
                         input longint d, input longint u, input longint w);
    step(0, 0, 0);
    step(0, 0, 0);
    cg[0] = a; cg[1] = b; cg[2] = c; cg[3] = d; co[0] = u; co[1] = w;
    drive_cfg();
  endtask

  task automatic sweep();
    int crd[12] = '{-1024, -1023, -640, -3, -1, 0, 1, 2, 100, 639, 640, 1023};
    int k = 0;
    foreach (crd[i]) begin
      foreach (crd[j]) begin
        step(1, crd[i], crd[j]);
        k++;
        if (k % 7 == 0) step(0, 0, 0);
      end
    end
  endtask

  task automatic mid_reset();
    step(1, 300, 200);
    step(1, -5, 9);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    check("R10", longint'(out_valid), 0);
    check("R10", longint'(out_coord), 0);
    rst = 1'b0;
    clear_model();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    cg = '{65536, 0, 0, 65536}; co = '{0, 0};
    drive_cfg();
    clear_model();
    // Reset with input activity present.
    in_valid = 1'b1; in_coord = {11'd7, 11'd3};
    repeat (3) @(negedge clk);
    check("R10", longint'(out_valid), 0);
    check("R10", longint'(out_coord), 0);
    rst = 1'b0; in_valid = 1'b0;

    // Field placement with identity gains.
    step(1, 5, -7, "R1", "R1");
    step(1, 300, -2, "R7", "R7");
    step(1, -1024, 1023, "R1", "R1");
    step(0, 0, 0);

    // Identity sweep.
    sweep();
    // Lane separation: X uses row one and ofs_x only, Y row two and ofs_y.
    new_cfg(131072, 0, 0, -65536, 100 <<< 16, -(37 <<< 16));
    step(1, 12, 34);
    step(1, -12, 34);
    sweep();
    // Rotation-like fractional gains with fractional offsets (floor).
    new_cfg(46341, -46341, 46341, 46341, (320 <<< 16) + 32768, -((240 <<< 16) + 16384));
    sweep();
    // Negative fractions: floor toward negative infinity.
    new_cfg(-19661, 13, 7, -3, -1, 255);
    sweep();
    // Positive rail.
    new_cfg(262143, 262143, 262143, 262143, (1 <<< 26) - 1, (1 <<< 26) - 1);
    sweep();
    // Negative rail.
    new_cfg(-262144, -262144, -262144, -262144, -(1 <<< 26), -(1 <<< 26));
    sweep();
    // Reset with results in flight.
    mid_reset();
    step(1, 1, 1);
    step(0, 0, 0);
    // Random configurations.
    for (int r = 0; r < 3; r++) begin
      new_cfg(longint'($urandom_range(0, 524287)) - 262144,
              longint'($urandom_range(0, 524287)) - 262144,
              longint'($urandom_range(0, 524287)) - 262144,
              longint'($urandom_range(0, 524287)) - 262144,
              longint'($urandom_range(0, 134217727)) - 67108864,
              longint'($urandom_range(0, 134217727)) - 67108864);
      sweep();
    end
    step(0, 0, 0);
    step(0, 0, 0);
    step(0, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule